// File: doc/BRIEF.md
# Ethernet Transmit Event and Halt Collector

This block sits beside an Ethernet MAC transmitter and its buffer-descriptor engine. It gathers their one-cycle status strobes into a sticky 32-bit event word, drives a maskable interrupt line and keeps a transmit-halt flag. Faults that stop the queue each set their own event bit. They also set a shared error bit and the halt flag. Descriptor updates are sorted by whether the descriptor closed its frame.

Software reads the event word and clears bits by writing ones to them. It programs an interrupt mask with the same bit layout, and it releases the halt flag with a dedicated strobe. The block also returns same-cycle requests to the MAC: truncate the frame, corrupt its CRC, or discard it.

Bit positions below are vector indices (bit 0 = LSB). They correspond to positions 6..16 counted from the MSB of the word.

Top module: `tx_event_ctrl`

## Requirements
- R1: A graceful-stop-done strobe or a pause-frame-done strobe sets event bit 25 on the next clock edge.
- R2: An oversize-frame strobe with huge-frame mode off sets event bit 24 on the next edge and raises `truncate_o` in the same cycle. With huge-frame mode on, the strobe has no effect.
- R3: A control-frame-sent strobe sets event bit 23 on the next edge.
- R4: A bus error, an accepted late collision, an accepted retry-limit strobe or a FIFO underrun sets event bit 22 and the halt flag on the next edge. The halt flag stays set until `halt_clr_i`. An error in the same cycle as the clear keeps it set.
- R5: A transmit descriptor update with its interrupt request set sets bit 21 when the descriptor is not the last of the frame, and bit 20 when it is. Without the interrupt request it sets neither bit.
- R6: In half-duplex mode a late collision sets bit 18 and raises `truncate_o` and `bad_crc_o` in the same cycle. In full-duplex mode it sets no bit, does not halt and raises no request.
- R7: In half-duplex mode a retry-limit strobe sets bit 17 and raises `discard_o` in the same cycle. In full-duplex mode it is ignored.
- R8: A FIFO underrun strobe sets bit 16.
- R9: A receive descriptor update with interrupt request set that is not the last of its frame sets bit 15. Any other receive update sets nothing.
- R10: Event bits are sticky. A write with `clr_wr_i` clears the bits where `clr_data_i` is one on the next edge. A set in the same cycle wins over the clear. Reserved bit 19 and all unassigned bits read zero.
- R11: `irq_o` is high exactly when some event bit is set whose mask bit is one. The mask is loaded by `mask_wr_i`.
- R12: While `rst_n` is low at a clock edge, the event word, mask and halt flag become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gstop_done_i | input | 1 | Graceful stop finished |
| pause_done_i | input | 1 | Pause frame finished |
| ctrl_sent_i | input | 1 | Control frame sent |
| txd_upd_i | input | 1 | Transmit descriptor updated |
| txd_irq_i | input | 1 | Interrupt request bit of that descriptor |
| txd_last_i | input | 1 | Descriptor is last of frame |
| frame_over_i | input | 1 | Frame length over programmed maximum |
| late_col_i | input | 1 | Late collision |
| retry_lim_i | input | 1 | Collision retry limit exceeded |
| fifo_unf_i | input | 1 | Transmit FIFO underrun |
| bus_err_i | input | 1 | System bus error |
| rxd_upd_i | input | 1 | Receive descriptor updated |
| rxd_irq_i | input | 1 | Interrupt request bit of receive descriptor |
| rxd_last_i | input | 1 | Receive descriptor is last of frame |
| half_duplex_i | input | 1 | Half-duplex mode |
| huge_en_i | input | 1 | Huge-frame mode enable |
| clr_wr_i | input | 1 | Write-one-to-clear strobe |
| clr_data_i | input | 32 | Bits to clear |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_data_i | input | 32 | New mask value |
| halt_clr_i | input | 1 | Release halt flag |
| event_o | output | 32 | Sticky event word |
| irq_o | output | 1 | Masked interrupt |
| halt_o | output | 1 | Transmit halted |
| truncate_o | output | 1 | Truncate current frame |
| bad_crc_o | output | 1 | Append deliberately bad CRC |
| discard_o | output | 1 | Discard current frame |

## Verification
The MAC requests `truncate_o`, `bad_crc_o` and `discard_o` are combinational. The bench checks them 1 ns after it drives a strobe, in the same cycle. Event bits, the mask and the halt flag change on the first clock edge after the strobe or write. The bench compares them at the following falling edge, against a model that it advances at that same rising edge. `irq_o` follows the registered event and mask values, so it is checked together with them.

// File: rtl/tx_evt_pkg.sv
// Package: bit positions of the transmit event word.
// Positions are given as distances from the MSB and converted to vector indices.
package tx_evt_pkg;
    localparam int EV_W = 32;

    localparam int B_GSC  = EV_W - 1 - 6;   // graceful stop / pause done
    localparam int B_BABT = EV_W - 1 - 7;   // babbling transmit
    localparam int B_TXC  = EV_W - 1 - 8;   // control frame sent
    localparam int B_TXE  = EV_W - 1 - 9;   // shared halting error
    localparam int B_TXB  = EV_W - 1 - 10;  // non-last descriptor
    localparam int B_TXF  = EV_W - 1 - 11;  // last descriptor
    localparam int B_RSVD = EV_W - 1 - 12;  // reserved, reads zero
    localparam int B_LC   = EV_W - 1 - 13;  // late collision
    localparam int B_CRL  = EV_W - 1 - 14;  // retry limit
    localparam int B_UNF  = EV_W - 1 - 15;  // FIFO underrun
    localparam int B_RXB  = EV_W - 1 - 16;  // receive non-last descriptor

    // Requests returned to the MAC in the strobe's own cycle
    typedef struct packed {
        logic truncate;
        logic bad_crc;
        logic discard;
        logic halt_err;
    } mac_req_t;
endpackage

// File: rtl/tx_evt_decode.sv
// Module: tx_evt_decode
// Turns the raw status strobes into a per-bit set vector and same-cycle MAC requests.
// Assumes every strobe is a single-cycle pulse; mode inputs are quasi-static.
module tx_evt_decode
    import tx_evt_pkg::*;
(
    input  logic            gstop_done_i,
    input  logic            pause_done_i,
    input  logic            ctrl_sent_i,
    input  logic            txd_upd_i,
    input  logic            txd_irq_i,
    input  logic            txd_last_i,
    input  logic            frame_over_i,
    input  logic            late_col_i,
    input  logic            retry_lim_i,
    input  logic            fifo_unf_i,
    input  logic            bus_err_i,
    input  logic            rxd_upd_i,
    input  logic            rxd_irq_i,
    input  logic            rxd_last_i,
    input  logic            half_duplex_i,
    input  logic            huge_en_i,
    output logic [EV_W-1:0] set_vec_o,
    output mac_req_t        req_o
);
    logic lc_ok, crl_ok, babble, txd_req, any_err;

    // Qualify the mode-dependent causes
    always_comb begin
        lc_ok   = late_col_i  & half_duplex_i;
        crl_ok  = retry_lim_i & half_duplex_i;
        babble  = frame_over_i & ~huge_en_i;
        txd_req = txd_upd_i & txd_irq_i;
        any_err = bus_err_i | lc_ok | crl_ok | fifo_unf_i;
    end

    // Build the set vector; unassigned positions stay zero
    always_comb begin
        set_vec_o         = '0;
        set_vec_o[B_GSC]  = gstop_done_i | pause_done_i;
        set_vec_o[B_BABT] = babble;
        set_vec_o[B_TXC]  = ctrl_sent_i;
        set_vec_o[B_TXE]  = any_err;
        set_vec_o[B_TXB]  = txd_req & ~txd_last_i;
        set_vec_o[B_TXF]  = txd_req &  txd_last_i;
        set_vec_o[B_LC]   = lc_ok;
        set_vec_o[B_CRL]  = crl_ok;
        set_vec_o[B_UNF]  = fifo_unf_i;
        set_vec_o[B_RXB]  = rxd_upd_i & rxd_irq_i & ~rxd_last_i;
    end

    // Requests back to the MAC datapath
    always_comb begin
        req_o.truncate = babble | lc_ok;
        req_o.bad_crc  = lc_ok;
        req_o.discard  = crl_ok;
        req_o.halt_err = any_err;
    end
endmodule

// File: rtl/tx_evt_sticky.sv
// Module: tx_evt_sticky
// Per-bit sticky register with write-one-to-clear; a set beats a clear in the same cycle.
// Assumes positions that are never set simply hold their reset value of zero.
module tx_evt_sticky #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_wr_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic r;
        // Hold, set or clear one event bit
        always_ff @(posedge clk) begin
            if (!rst_n) r <= 1'b0;
            else        r <= set_i[i] | (r & ~(clr_wr_i & clr_data_i[i]));
        end
        assign q_o[i] = r;
    end
endmodule

// File: rtl/tx_evt_mask.sv
// Module: tx_evt_mask
// Holds the interrupt mask and reduces masked events to one interrupt line.
// Assumes the mask shares the event word's layout.
module tx_evt_mask #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_wr_i,
    input  logic [W-1:0] mask_data_i,
    input  logic [W-1:0] event_i,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);
    // Load the mask on a software write
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_o <= '0;
        else if (mask_wr_i) mask_o <= mask_data_i;
    end

    // Combine masked events
    always_comb irq_o = |(event_i & mask_o);
endmodule

// File: rtl/tx_event_ctrl.sv
// Module: tx_event_ctrl (top)
// Collects transmit-side status into a sticky event word, a masked interrupt
// and a sticky halt flag, and returns truncate/bad-CRC/discard requests.
// Assumes synchronous active-low reset and single-cycle strobes.
module tx_event_ctrl
    import tx_evt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gstop_done_i,
    input  logic            pause_done_i,
    input  logic            ctrl_sent_i,
    input  logic            txd_upd_i,
    input  logic            txd_irq_i,
    input  logic            txd_last_i,
    input  logic            frame_over_i,
    input  logic            late_col_i,
    input  logic            retry_lim_i,
    input  logic            fifo_unf_i,
    input  logic            bus_err_i,
    input  logic            rxd_upd_i,
    input  logic            rxd_irq_i,
    input  logic            rxd_last_i,
    input  logic            half_duplex_i,
    input  logic            huge_en_i,
    input  logic            clr_wr_i,
    input  logic [EV_W-1:0] clr_data_i,
    input  logic            mask_wr_i,
    input  logic [EV_W-1:0] mask_data_i,
    input  logic            halt_clr_i,
    output logic [EV_W-1:0] event_o,
    output logic            irq_o,
    output logic            halt_o,
    output logic            truncate_o,
    output logic            bad_crc_o,
    output logic            discard_o
);
    logic [EV_W-1:0] set_vec;
    logic [EV_W-1:0] mask_q;
    mac_req_t        req;

    tx_evt_decode u_decode (
        .gstop_done_i (gstop_done_i),
        .pause_done_i (pause_done_i),
        .ctrl_sent_i  (ctrl_sent_i),
        .txd_upd_i    (txd_upd_i),
        .txd_irq_i    (txd_irq_i),
        .txd_last_i   (txd_last_i),
        .frame_over_i (frame_over_i),
        .late_col_i   (late_col_i),
        .retry_lim_i  (retry_lim_i),
        .fifo_unf_i   (fifo_unf_i),
        .bus_err_i    (bus_err_i),
        .rxd_upd_i    (rxd_upd_i),
        .rxd_irq_i    (rxd_irq_i),
        .rxd_last_i   (rxd_last_i),
        .half_duplex_i(half_duplex_i),
        .huge_en_i    (huge_en_i),
        .set_vec_o    (set_vec),
        .req_o        (req)
    );

    tx_evt_sticky #(.W(EV_W)) u_sticky (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .clr_wr_i  (clr_wr_i),
        .clr_data_i(clr_data_i),
        .q_o       (event_o)
    );

    tx_evt_mask #(.W(EV_W)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_wr_i  (mask_wr_i),
        .mask_data_i(mask_data_i),
        .event_i    (event_o),
        .mask_o     (mask_q),
        .irq_o      (irq_o)
    );

    // Halt flag: set by any halting error, released only by software
    always_ff @(posedge clk) begin
        if (!rst_n)            halt_o <= 1'b0;
        else if (req.halt_err) halt_o <= 1'b1;
        else if (halt_clr_i)   halt_o <= 1'b0;
    end

    // Same-cycle requests to the MAC
    always_comb begin
        truncate_o = req.truncate;
        bad_crc_o  = req.bad_crc;
        discard_o  = req.discard;
    end
endmodule

// File: rtl/tx_event_ctrl_chk.sv
// Module: tx_event_ctrl_chk
// Property checker bound to tx_event_ctrl; observes ports and the mask register.
module tx_event_ctrl_chk
    import tx_evt_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            txd_upd_i,
    input logic            txd_irq_i,
    input logic            txd_last_i,
    input logic            frame_over_i,
    input logic            fifo_unf_i,
    input logic            bus_err_i,
    input logic            half_duplex_i,
    input logic            huge_en_i,
    input logic            clr_wr_i,
    input logic            halt_clr_i,
    input logic [EV_W-1:0] event_o,
    input logic [EV_W-1:0] mask_q,
    input logic            irq_o,
    input logic            halt_o,
    input logic            truncate_o,
    input logic            bad_crc_o,
    input logic            discard_o
);
    p_babble_trunc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_over_i && !huge_en_i) |-> truncate_o);
    p_babble_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_over_i && !huge_en_i) |=> event_o[B_BABT]);
    p_err_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err_i || fifo_unf_i) |=> (halt_o && event_o[B_TXE]));
    p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && !halt_clr_i) |=> halt_o);
    p_last_desc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_upd_i && txd_irq_i && txd_last_i) |=> event_o[B_TXF]);
    p_fd_no_crc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !half_duplex_i |-> !bad_crc_o);
    p_fd_no_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !half_duplex_i |-> !discard_o);
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr_i |=> ((event_o & $past(event_o)) == $past(event_o)));
    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !event_o[B_RSVD]);
    p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((event_o & mask_q) != '0));
endmodule

bind tx_event_ctrl tx_event_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .txd_upd_i    (txd_upd_i),
    .txd_irq_i    (txd_irq_i),
    .txd_last_i   (txd_last_i),
    .frame_over_i (frame_over_i),
    .fifo_unf_i   (fifo_unf_i),
    .bus_err_i    (bus_err_i),
    .half_duplex_i(half_duplex_i),
    .huge_en_i    (huge_en_i),
    .clr_wr_i     (clr_wr_i),
    .halt_clr_i   (halt_clr_i),
    .event_o      (event_o),
    .mask_q       (mask_q),
    .irq_o        (irq_o),
    .halt_o       (halt_o),
    .truncate_o   (truncate_o),
    .bad_crc_o    (bad_crc_o),
    .discard_o    (discard_o)
);

// File: tb/test_tx_event_ctrl.sv
// Bench for tx_event_ctrl: behavioural reference model compared every clock.
module test_tx_event_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gstop_done_i = 0, pause_done_i = 0, ctrl_sent_i = 0;
    logic txd_upd_i = 0, txd_irq_i = 0, txd_last_i = 0;
    logic frame_over_i = 0, late_col_i = 0, retry_lim_i = 0;
    logic fifo_unf_i = 0, bus_err_i = 0;
    logic rxd_upd_i = 0, rxd_irq_i = 0, rxd_last_i = 0;
    logic half_duplex_i = 0, huge_en_i = 0;
    logic clr_wr_i = 0, mask_wr_i = 0, halt_clr_i = 0;
    logic [31:0] clr_data_i = '0, mask_data_i = '0;
    logic [31:0] event_o;
    logic irq_o, halt_o, truncate_o, bad_crc_o, discard_o;

    int n_chk = 0;
    int n_err = 0;
    bit [31:0] m_ev = '0, m_mask = '0;
    bit m_halt = 0;

    always #4 clk = ~clk;   // 125 MHz

    tx_event_ctrl i_tx_event_ctrl (
        .clk(clk), .rst_n(rst_n),
        .gstop_done_i(gstop_done_i), .pause_done_i(pause_done_i),
        .ctrl_sent_i(ctrl_sent_i), .txd_upd_i(txd_upd_i),
        .txd_irq_i(txd_irq_i), .txd_last_i(txd_last_i),
        .frame_over_i(frame_over_i), .late_col_i(late_col_i),
        .retry_lim_i(retry_lim_i), .fifo_unf_i(fifo_unf_i),
        .bus_err_i(bus_err_i), .rxd_upd_i(rxd_upd_i),
        .rxd_irq_i(rxd_irq_i), .rxd_last_i(rxd_last_i),
        .half_duplex_i(half_duplex_i), .huge_en_i(huge_en_i),
        .clr_wr_i(clr_wr_i), .clr_data_i(clr_data_i),
        .mask_wr_i(mask_wr_i), .mask_data_i(mask_data_i),
        .halt_clr_i(halt_clr_i), .event_o(event_o), .irq_o(irq_o),
        .halt_o(halt_o), .truncate_o(truncate_o),
        .bad_crc_o(bad_crc_o), .discard_o(discard_o)
    );

    function automatic string tag_of(int b);
        case (b)
            25: return "R1";  24: return "R2";  23: return "R3";
            22: return "R4";  21: return "R5";  20: return "R5";
            18: return "R6";  17: return "R7";  16: return "R8";
            15: return "R9";  default: return "R10";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Advance the model at a rising edge using the inputs held there
    task automatic model_edge();
        bit [31:0] s;
        bit lc, crl, err;
        if (!rst_n) begin
            m_ev = '0; m_mask = '0; m_halt = 0;
            return;
        end
        lc  = late_col_i && half_duplex_i;
        crl = retry_lim_i && half_duplex_i;
        err = bus_err_i || lc || crl || fifo_unf_i;
        s = '0;
        if (gstop_done_i || pause_done_i) s[25] = 1;
        if (frame_over_i && !huge_en_i)   s[24] = 1;
        if (ctrl_sent_i)                  s[23] = 1;
        if (err)                          s[22] = 1;
        if (txd_upd_i && txd_irq_i) begin
            if (txd_last_i) s[20] = 1; else s[21] = 1;
        end
        if (lc)  s[18] = 1;
        if (crl) s[17] = 1;
        if (fifo_unf_i) s[16] = 1;
        if (rxd_upd_i && rxd_irq_i && !rxd_last_i) s[15] = 1;
        if (clr_wr_i) m_ev = m_ev & ~clr_data_i;
        m_ev = m_ev | s;
        if (mask_wr_i) m_mask = mask_data_i;
        if (err) m_halt = 1;
        else if (halt_clr_i) m_halt = 0;
    endtask

    task automatic idle();
        gstop_done_i = 0; pause_done_i = 0; ctrl_sent_i = 0;
        txd_upd_i = 0; txd_irq_i = 0; txd_last_i = 0;
        frame_over_i = 0; late_col_i = 0; retry_lim_i = 0;
        fifo_unf_i = 0; bus_err_i = 0;
        rxd_upd_i = 0; rxd_irq_i = 0; rxd_last_i = 0;
        clr_wr_i = 0; mask_wr_i = 0; halt_clr_i = 0;
    endtask

    // One cycle: check same-cycle requests, clock, then check registered state
    task automatic step();
        bit lc, crl;
        #1;
        lc  = late_col_i && half_duplex_i;
        crl = retry_lim_i && half_duplex_i;
        check("R2", "truncate_o", 32'(truncate_o), 32'((frame_over_i && !huge_en_i) || lc));
        check("R6", "bad_crc_o",  32'(bad_crc_o),  32'(lc));
        check("R7", "discard_o",  32'(discard_o),  32'(crl));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        for (int b = 0; b < 32; b++)
            check(tag_of(b), $sformatf("event_o[%0d]", b), 32'(event_o[b]), 32'(m_ev[b]));
        check("R4",  "halt_o", 32'(halt_o), 32'(m_halt));
        check("R11", "irq_o",  32'(irq_o),  32'(|(m_ev & m_mask)));
        idle();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R12: reset clears everything
        step(); step();
        check("R12", "event_o reset", event_o, 32'h0);
        check("R12", "halt_o reset", 32'(halt_o), 32'h0);
        rst_n = 1;
        step();

        // R11: enable all interrupts
        mask_wr_i = 1; mask_data_i = 32'hFFFF_FFFF; step();
        gstop_done_i = 1; step();                           // R1
        clr_wr_i = 1; clr_data_i = 32'hFFFF_FFFF; step();   // R10 clear all
        pause_done_i = 1; step();                           // R1 pause path
        frame_over_i = 1; huge_en_i = 1; step();            // R2 ignored with huge frames
        huge_en_i = 0; frame_over_i = 1; step();            // R2 babble
        ctrl_sent_i = 1; step();                            // R3
        txd_upd_i = 1; txd_irq_i = 1; txd_last_i = 0; step(); // R5 buffer
        txd_upd_i = 1; txd_irq_i = 1; txd_last_i = 1; step(); // R5 frame
        clr_wr_i = 1; clr_data_i = 32'hFFFF_FFFF; step();
        txd_upd_i = 1; txd_irq_i = 0; txd_last_i = 1; step(); // R5 no request
        rxd_upd_i = 1; rxd_irq_i = 1; rxd_last_i = 1; step(); // R9 last: nothing
        rxd_upd_i = 1; rxd_irq_i = 1; rxd_last_i = 0; step(); // R9 buffer
        half_duplex_i = 0; late_col_i = 1; retry_lim_i = 1; step(); // R6 R7 full duplex ignored
        fifo_unf_i = 1; step();                             // R8 and R4 halt
        step();
        halt_clr_i = 1; bus_err_i = 1; step();              // R4 set wins
        halt_clr_i = 1; step();                             // R4 release
        half_duplex_i = 1; late_col_i = 1; step();          // R6 half duplex
        retry_lim_i = 1; step();                            // R7 half duplex
        halt_clr_i = 1; step();
        clr_wr_i = 1; clr_data_i = 32'h0002_0000; retry_lim_i = 1; step(); // R10 set beats clear
        clr_wr_i = 1; clr_data_i = 32'h0008_0000; step();   // R10 reserved stays zero
        mask_wr_i = 1; mask_data_i = 32'h0000_0001; step(); // R11 masked off
        mask_wr_i = 1; mask_data_i = 32'h0004_0000; step(); // R11 late-collision bit only

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            gstop_done_i = ($urandom % 16) == 0;
            pause_done_i = ($urandom % 16) == 0;
            ctrl_sent_i  = ($urandom % 16) == 0;
            txd_upd_i    = ($urandom % 4) == 0;
            txd_irq_i    = $urandom % 2;
            txd_last_i   = $urandom % 2;
            frame_over_i = ($urandom % 16) == 0;
            late_col_i   = ($urandom % 16) == 0;
            retry_lim_i  = ($urandom % 16) == 0;
            fifo_unf_i   = ($urandom % 32) == 0;
            bus_err_i    = ($urandom % 32) == 0;
            rxd_upd_i    = ($urandom % 4) == 0;
            rxd_irq_i    = $urandom % 2;
            rxd_last_i   = $urandom % 2;
            if (($urandom % 50) == 0) half_duplex_i = ~half_duplex_i;
            if (($urandom % 50) == 0) huge_en_i = ~huge_en_i;
            clr_wr_i     = ($urandom % 6) == 0;
            clr_data_i   = $urandom;
            mask_wr_i    = ($urandom % 20) == 0;
            mask_data_i  = $urandom;
            halt_clr_i   = ($urandom % 8) == 0;
            if (($urandom % 500) == 0) rst_n = 0; else rst_n = 1;   // R12
            step();
        end
        rst_n = 1;
        step();
        finish_run();
    end
endmodule